// File: doc/BRIEF.md
# Golden-Envelope Amplitude Deviation Scorer

This block screens analogue-to-digital converters using their digital output alone. It takes one period of a converter's output that has already been reconstructed and aligned. The record has a fixed length and is split into four equal sections that sit back to back. In training mode the block takes records from devices known to be good. For every sample position it keeps the lowest and the highest value seen so far, so the good population defines a band that changes from one position to the next.

In test mode the block takes one record from the device under test. For each sample it measures how far the value lies outside the band at that position, and it sums this excursion over each section. It also sums the band width over the same section. After the last sample, a sequential divider turns each section's pair of sums into a 16-bit fraction. The four fractions are reported one at a time, in section order. A single fail flag is set when any fraction exceeds a programmable threshold. The record runs on a single-cycle sample strobe, and idle cycles may appear anywhere between samples.

Top module: `env_dev_scorer`

## Requirements
- R1: After reset, score_valid, done and fail are all low, and the next accepted sample is position 0 of a record.
- R2: A training record flagged as first sets both the low and the high bound of every position to that record's sample, so the band has zero width.
- R3: A training record that is not flagged as first lowers the low bound and raises the high bound wherever its sample lies outside the stored band. The low bound never exceeds the high bound.
- R4: In test mode, a sample above its high bound contributes (sample minus high bound), a sample below its low bound contributes (low bound minus sample), and a sample inside the band or on its edges contributes zero.
- R5: Section k (k = 0..3) covers positions k*SEC_LEN to k*SEC_LEN+SEC_LEN-1. Its excursion and width sums include only those positions.
- R6: A section score equals floor(excursion_sum * 65536 / width_sum) when the excursion sum is below the width sum. Otherwise, including the case of zero width, the score is 0xFFFF.
- R7: After a test record, score_valid pulses exactly four times with score_sec 0, 1, 2, 3 in that order. done pulses for one cycle, together with the section-3 score.
- R8: fail is updated when done pulses. It is 1 when any of the four scores is strictly greater than threshold, and it holds that value until the next done.
- R9: Cycles with s_valid low, and samples presented while the four scores are being computed, neither advance the position nor change the band or the sums.
- R10: mode_train and first_rec are read at a record's first sample. Changing them later in the record has no effect on that record.
- R11: The excursion and width accumulators cannot overflow, even for full-scale 12-bit differences at every position of a section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_train | input | 1 | 1 = training record, 0 = test record (read at position 0) |
| first_rec | input | 1 | In training, this record starts a new band (read at position 0) |
| s_valid | input | 1 | Sample strobe |
| s_data | input | 12 | Sample value, unsigned |
| threshold | input | 16 | Fail threshold for section scores |
| score_valid | output | 1 | One-cycle pulse: score and score_sec are valid |
| score_sec | output | 2 | Section index of the current score |
| score | output | 16 | Section score as an unsigned fraction |
| done | output | 1 | One-cycle pulse after the last section score |
| fail | output | 1 | Pass/fail result of the most recent test record |

## Verification
On every cycle, the assertions check that the stored low bound never exceeds the high bound and that neither accumulator carries out of its width. They also check that each non-saturated quotient lies inside the exact floor bounds of the fraction, that done is a single pulse coinciding with the last section's score, and that fail changes only at done. Other properties can only be shown by the bench's scenarios against its own model of the band. These include which section a sample's excursion lands in, the exact score values, that a first-flagged record replaces the band, that mode changes in the middle of a record are ignored, and that samples or idle cycles during scoring leave later results untouched.

// File: rtl/env_pkg.sv
package env_pkg;
  localparam int SMP_W  = 12;
  localparam int FRAC_W = 16;

  typedef logic [SMP_W-1:0] smp_t;

  typedef enum logic {PH_SCAN, PH_SCORE} phase_t;

  // distance of a sample outside the band [lo, hi]; zero inside
  function automatic smp_t band_excess(smp_t s, smp_t lo, smp_t hi);
    if (s > hi) return s - hi;
    else if (s < lo) return lo - s;
    else return '0;
  endfunction

  function automatic smp_t lower_of(smp_t a, smp_t b);
    return (a < b) ? a : b;
  endfunction

  function automatic smp_t upper_of(smp_t a, smp_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/env_band_store.sv
module env_band_store
  import env_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  smp_t             wr_lo,
  input  smp_t             wr_hi,
  input  logic [IDX_W-1:0] rd_idx,
  output smp_t             rd_lo,
  output smp_t             rd_hi
);
  smp_t lo_all [DEPTH];
  smp_t hi_all [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    smp_t lo_q, hi_q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) begin
        lo_q <= wr_lo;
        hi_q <= wr_hi;
      end
    end
    assign lo_all[g] = lo_q;
    assign hi_all[g] = hi_q;
  end

  assign rd_lo = lo_all[rd_idx];
  assign rd_hi = hi_all[rd_idx];

  // R3: the band written back is always ordered
  assert_band_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_lo <= wr_hi));
endmodule

// File: rtl/env_sec_acc.sv
module env_sec_acc
  import env_pkg::*;
#(
  parameter int NUM_SEC = 4,
  parameter int SEC_W   = $clog2(NUM_SEC),
  parameter int ACC_W   = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sec_end,
  input  logic [SEC_W-1:0] sec_idx,
  input  smp_t             dev,
  input  smp_t             wid,
  input  logic [SEC_W-1:0] rd_sec,
  output logic [ACC_W-1:0] rd_dev,
  output logic [ACC_W-1:0] rd_wid
);
  logic [ACC_W-1:0] run_dev, run_wid;
  logic [ACC_W:0]   dev_sum, wid_sum;
  logic [ACC_W-1:0] dev_all [NUM_SEC];
  logic [ACC_W-1:0] wid_all [NUM_SEC];

  assign dev_sum = {1'b0, run_dev} + (ACC_W+1)'(dev);
  assign wid_sum = {1'b0, run_wid} + (ACC_W+1)'(wid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_dev <= '0;
      run_wid <= '0;
    end else if (en) begin
      run_dev <= sec_end ? '0 : dev_sum[ACC_W-1:0];
      run_wid <= sec_end ? '0 : wid_sum[ACC_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_slot
    logic [ACC_W-1:0] d_q, w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        w_q <= '0;
      end else if (en && sec_end && sec_idx == SEC_W'(g)) begin
        d_q <= dev_sum[ACC_W-1:0];
        w_q <= wid_sum[ACC_W-1:0];
      end
    end
    assign dev_all[g] = d_q;
    assign wid_all[g] = w_q;
  end

  assign rd_dev = dev_all[rd_sec];
  assign rd_wid = wid_all[rd_sec];

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (!dev_sum[ACC_W] && !wid_sum[ACC_W]));
endmodule

// File: rtl/env_frac_div.sv
module env_frac_div #(
  parameter int NUM_W  = 17,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NUM_W-1:0]  num,
  input  logic [NUM_W-1:0]  den,
  output logic              done,
  output logic [FRAC_W-1:0] quot
);
  localparam int CNT_W = $clog2(FRAC_W + 1);
  localparam int PW    = NUM_W + FRAC_W + 1;

  logic [NUM_W-1:0] rem, num_q, den_q;
  logic [NUM_W:0]   rem2;
  logic [CNT_W-1:0] cnt;
  logic             busy, sat_q, ge;

  assign rem2 = {rem, 1'b0};
  assign ge   = rem2 >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0; num_q <= '0; den_q <= '0; cnt <= '0;
      busy <= 1'b0; sat_q <= 1'b0; done <= 1'b0; quot <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        num_q <= num;
        den_q <= den;
        quot  <= '0;
        if (num >= den) begin
          sat_q <= 1'b1;
          quot  <= '1;
          done  <= 1'b1;
        end else begin
          sat_q <= 1'b0;
          rem   <= num;
          cnt   <= CNT_W'(FRAC_W);
          busy  <= 1'b1;
        end
      end else if (busy) begin
        rem  <= ge ? NUM_W'(rem2 - {1'b0, den_q}) : rem2[NUM_W-1:0];
        quot <= {quot[FRAC_W-2:0], ge};
        cnt  <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  logic [PW-1:0] prod_lo, prod_hi, scaled;
  assign prod_lo = PW'(quot) * PW'(den_q);
  assign prod_hi = (PW'(quot) + PW'(1)) * PW'(den_q);
  assign scaled  = PW'(num_q) << FRAC_W;

  // R6: quotient is the floor of num*2^FRAC_W/den
  assert_quot_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sat_q) |-> (prod_lo <= scaled && prod_hi > scaled));
endmodule

// File: rtl/env_dev_scorer.sv
module env_dev_scorer
  import env_pkg::*;
#(
  parameter int SEC_LEN = 16,
  parameter int NUM_SEC = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_train,
  input  logic                       first_rec,
  input  logic                       s_valid,
  input  logic [11:0]                s_data,
  input  logic [15:0]                threshold,
  output logic                       score_valid,
  output logic [$clog2(NUM_SEC)-1:0] score_sec,
  output logic [15:0]                score,
  output logic                       done,
  output logic                       fail
);
  localparam int REC_LEN = SEC_LEN * NUM_SEC;
  localparam int IDX_W   = $clog2(REC_LEN);
  localparam int POS_W   = $clog2(SEC_LEN);
  localparam int SEC_W   = $clog2(NUM_SEC);
  localparam int ACC_W   = SMP_W + $clog2(SEC_LEN + 1);

  phase_t           phase;
  logic [IDX_W-1:0] idx;
  logic [POS_W-1:0] pos;
  logic [SEC_W-1:0] sec_in, sc_sec;
  logic             mode_q, first_q, div_start, fail_run;

  // named events used by the assertions and by the datapath
  logic at_start, eff_train, eff_first, take, sec_end, rec_end, wr_en, acc_en;
  assign at_start  = (idx == '0);
  assign eff_train = at_start ? mode_train : mode_q;
  assign eff_first = at_start ? first_rec  : first_q;
  assign take      = s_valid && (phase == PH_SCAN);
  assign sec_end   = (pos == POS_W'(SEC_LEN - 1));
  assign rec_end   = take && sec_end && (sec_in == SEC_W'(NUM_SEC - 1));
  assign wr_en     = take && eff_train;
  assign acc_en    = take && !eff_train;

  smp_t rd_lo, rd_hi, wr_lo, wr_hi, dev, wid;
  assign wr_lo = eff_first ? s_data : lower_of(rd_lo, s_data);
  assign wr_hi = eff_first ? s_data : upper_of(rd_hi, s_data);
  assign dev   = band_excess(s_data, rd_lo, rd_hi);
  assign wid   = rd_hi - rd_lo;

  env_band_store #(.DEPTH(REC_LEN), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_idx(idx), .rd_lo(rd_lo), .rd_hi(rd_hi));

  logic [ACC_W-1:0] sum_dev, sum_wid;
  env_sec_acc #(.NUM_SEC(NUM_SEC), .SEC_W(SEC_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(acc_en), .sec_end(sec_end), .sec_idx(sec_in),
    .dev(dev), .wid(wid), .rd_sec(sc_sec), .rd_dev(sum_dev), .rd_wid(sum_wid));

  logic              div_done;
  logic [FRAC_W-1:0] div_quot;
  env_frac_div #(.NUM_W(ACC_W), .FRAC_W(FRAC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(sum_dev), .den(sum_wid),
    .done(div_done), .quot(div_quot));

  logic over;
  assign over = div_quot > threshold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SCAN; idx <= '0; pos <= '0; sec_in <= '0; sc_sec <= '0;
      mode_q <= 1'b0; first_q <= 1'b0; div_start <= 1'b0; fail_run <= 1'b0;
      score_valid <= 1'b0; score_sec <= '0; score <= '0; done <= 1'b0; fail <= 1'b0;
    end else begin
      score_valid <= 1'b0;
      done        <= 1'b0;
      div_start   <= 1'b0;
      if (take) begin
        if (at_start) begin
          mode_q  <= mode_train;
          first_q <= first_rec;
        end
        idx    <= rec_end ? '0 : idx + 1'b1;
        pos    <= sec_end ? '0 : pos + 1'b1;
        if (sec_end) sec_in <= rec_end ? '0 : sec_in + 1'b1;
        if (rec_end && !eff_train) begin
          phase     <= PH_SCORE;
          sc_sec    <= '0;
          div_start <= 1'b1;
          fail_run  <= 1'b0;
        end
      end
      if (phase == PH_SCORE && div_done) begin
        score_valid <= 1'b1;
        score       <= div_quot;
        score_sec   <= sc_sec;
        if (sc_sec == SEC_W'(NUM_SEC - 1)) begin
          done  <= 1'b1;
          fail  <= fail_run | over;
          phase <= PH_SCAN;
        end else begin
          fail_run  <= fail_run | over;
          sc_sec    <= sc_sec + 1'b1;
          div_start <= 1'b1;
        end
      end
    end
  end

  assert_done_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (score_valid && score_sec == SEC_W'(NUM_SEC - 1)));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_fail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(fail));
endmodule

// File: tb/sim_env_dev_scorer.sv
`timescale 1ns/1ps
module sim_env_dev_scorer;
  localparam int SEC_LEN = 16;
  localparam int NUM_SEC = 4;
  localparam int REC_LEN = SEC_LEN * NUM_SEC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_train = 1'b0, first_rec = 1'b0, s_valid = 1'b0;
  logic [11:0] s_data = '0;
  logic [15:0] threshold = '0;
  logic        score_valid, done, fail;
  logic [1:0]  score_sec;
  logic [15:0] score;

  always #2 clk = ~clk;

  env_dev_scorer #(.SEC_LEN(SEC_LEN), .NUM_SEC(NUM_SEC)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_train(mode_train), .first_rec(first_rec),
    .s_valid(s_valid), .s_data(s_data), .threshold(threshold),
    .score_valid(score_valid), .score_sec(score_sec), .score(score),
    .done(done), .fail(fail));

  int n_cmp = 0, n_bad = 0;
  int gmin [REC_LEN];
  int gmax [REC_LEN];
  int rec  [REC_LEN];
  int exp_sc [NUM_SEC];
  bit exp_fail;
  bit finished = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int clamp12(int v);
    if (v < 0) return 0;
    if (v > 4095) return 4095;
    return v;
  endfunction

  function automatic int base_wave(int i);
    if (i < 12) return 300;
    if (i < 20) return 300 + (i - 12) * 400;
    if (i < 44) return 3500;
    if (i < 52) return 3500 - (i - 44) * 400;
    return 300;
  endfunction

  function automatic int ref_score(int d, int w);
    if (w == 0 || d >= w) return 65535;
    return int'((longint'(d) << 16) / longint'(w));
  endfunction

  task automatic model_train(bit first);
    for (int i = 0; i < REC_LEN; i++) begin
      if (first) begin gmin[i] = rec[i]; gmax[i] = rec[i]; end
      else begin
        if (rec[i] < gmin[i]) gmin[i] = rec[i];
        if (rec[i] > gmax[i]) gmax[i] = rec[i];
      end
    end
  endtask

  task automatic model_expect(int thr);
    exp_fail = 0;
    for (int s = 0; s < NUM_SEC; s++) begin
      int d = 0, w = 0;
      for (int p = 0; p < SEC_LEN; p++) begin
        int i = s * SEC_LEN + p;
        if (rec[i] > gmax[i]) d += rec[i] - gmax[i];
        else if (rec[i] < gmin[i]) d += gmin[i] - rec[i];
        w += gmax[i] - gmin[i];
      end
      exp_sc[s] = ref_score(d, w);
      if (exp_sc[s] > thr) exp_fail = 1;
    end
  endtask

  // mode inputs flip after the first sample (R10)
  task automatic drive_record(bit train, bit first, bit gaps);
    for (int i = 0; i < REC_LEN; i++) begin
      if (gaps) begin
        while ($urandom_range(0, 2) == 0) begin
          @(negedge clk);
          s_valid = 1'b0;
          s_data  = 12'($urandom_range(0, 4095));
        end
      end
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = 12'(rec[i]);
      mode_train = (i == 0) ? train : !train;
      first_rec  = (i == 0) ? first : !first;
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic train_rec(bit first, bit gaps);
    drive_record(1'b1, first, gaps);
    model_train(first);
  endtask

  task automatic test_rec(int thr, bit gaps, bit junk, string tag);
    int k = 0;
    bit got = 0;
    threshold = 16'(thr);
    model_expect(thr);
    drive_record(1'b0, 1'b0, gaps);
    for (int c = 0; c < 400 && !got; c++) begin
      if (c > 0) @(negedge clk);
      if (junk) begin
        s_valid = 1'($urandom_range(0, 1));
        s_data  = 12'($urandom_range(0, 4095));
      end
      if (score_valid) begin
        chk(k < NUM_SEC && score_sec == 2'(k), {tag, " R7 section order"}, score_sec, k);
        if (k < NUM_SEC)
          chk(score == 16'(exp_sc[k]), {tag, " R6 score"}, score, exp_sc[k]);
        k++;
      end
      if (done) begin
        got = 1;
        chk(k == NUM_SEC, {tag, " R7 done with last score"}, k, NUM_SEC);
        chk(fail == exp_fail, {tag, " R8 fail flag"}, fail, exp_fail);
      end
    end
    s_valid = 1'b0;
    if (!got) chk(0, {tag, " R7 done never seen"}, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(score_valid == 0 && done == 0 && fail == 0, "R1 reset outputs",
        {score_valid, done, fail}, 0);

    // R2: single first golden record gives zero width -> saturated scores
    for (int i = 0; i < REC_LEN; i++) rec[i] = clamp12(base_wave(i) + $urandom_range(0, 40));
    train_rec(1'b1, 1'b0);
    test_rec(32768, 1'b0, 1'b0, "R2 zero-width band");

    // R3 / R9: two more golden records with idle gaps
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < REC_LEN; i++) rec[i] = clamp12(base_wave(i) + $urandom_range(0, 40));
      train_rec(1'b0, 1'b1);
    end

    // R4 / R10: inside band, threshold 0 must pass
    for (int i = 0; i < REC_LEN; i++) rec[i] = (gmin[i] + gmax[i]) / 2;
    test_rec(0, 1'b1, 1'b0, "R4 R10 inside band");
    for (int i = 0; i < REC_LEN; i++) rec[i] = gmax[i];
    test_rec(0, 1'b0, 1'b0, "R4 on upper edge");

    // R5: excursions only in section 2
    for (int i = 0; i < REC_LEN; i++) rec[i] = (gmin[i] + gmax[i]) / 2;
    rec[40] = clamp12(gmax[40] + 30);
    rec[37] = clamp12(gmin[37] - 25);
    test_rec(65535, 1'b0, 1'b0, "R5 section 2 only");
    begin
      int s2;
      model_expect(65535);
      s2 = exp_sc[2];
      test_rec(s2, 1'b0, 1'b0, "R8 threshold equal");
      if (s2 > 0) test_rec(s2 - 1, 1'b0, 1'b0, "R8 threshold below");
    end

    // R9: samples thrown in during scoring, then a clean repeat
    test_rec(1000, 1'b0, 1'b1, "R9 junk during scoring");
    test_rec(1000, 1'b0, 1'b0, "R9 after junk");

    // random test records
    for (int r = 0; r < 12; r++) begin
      for (int i = 0; i < REC_LEN; i++)
        rec[i] = clamp12(base_wave(i) + int'($urandom_range(0, 90)) - 25);
      test_rec(int'($urandom_range(0, 20000)), 1'($urandom_range(0, 1)), 1'b0, "R4 R6 random");
    end

    // R11: full-scale sums
    for (int i = 0; i < REC_LEN; i++) rec[i] = 0;
    train_rec(1'b1, 1'b0);
    for (int i = 0; i < REC_LEN; i++) rec[i] = 4095;
    test_rec(65534, 1'b0, 1'b0, "R11 full excursion");
    train_rec(1'b0, 1'b0);
    for (int i = 0; i < REC_LEN; i++) rec[i] = 2048;
    test_rec(0, 1'b0, 1'b0, "R11 full width");
    for (int i = 0; i < REC_LEN; i++) rec[i] = (i % 2 == 0) ? 0 : 4095;
    test_rec(0, 1'b0, 1'b0, "R4 R11 band edges");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule